// File: doc/BRIEF.md
# Device Lifecycle and Debug-Access Controller

This block keeps the security lifecycle state of a device and turns it into the permission signals for the debug port. It also produces the status flags that the rest of the chip uses. An external persistent store presents the saved state on `loadState`, and the block captures that value while reset is held. After reset the state moves only on a small set of commands:

- advance, which provisions the device or onboards it;
- retire, which decommissions it;
- reclaim, which sends a decommissioned part back to manufacturing.

Debug access is graded. Each request names a level: diagnostics, nonsecure, application-root, or platform-root. A request is granted only while the authorisation input is high and the current state permits it. Granting a level also opens every lower level.

Opening the platform-root level outside manufacturing throws the device back into the manufacturing state. The device then has to pass through the full provisioning flow again before it can report itself as attestable. Entering the decommissioned state asks for all root-of-trust parameters to be erased and marks the secrets as invalid.

Top module: `lifecycle_guard`

## Requirements
- R1: While `rstN` is low the state register takes `loadState`. A legal one-hot value appears unchanged on `lcState` after reset. The encodings are manufacturing 4'b0001, shipped 4'b0010, secured 4'b0100 and retired 4'b1000. All debug enables, `nsDbgSeen` and the application flag start at 0, and `appActive` reads 1 in the secured state.
- R2: Any `loadState` that is not one-hot (for example 4'b0110 or 4'b0000) decodes to retired (4'b1000), with `eraseReq` high and `secretsValid` low.
- R3: `cmdCode` 2'b01 (advance) in manufacturing moves the state to shipped at the next edge. This happens only when `rotProvisioned`, `dbgPortLocked` and `secureBootOn` are all high and `dbgAuth` is low. Otherwise the command is ignored. `cmdCode` 2'b00 is no operation.
- R4: A pulse on `appProvReq` sets `appActive` at the next edge only in the shipped or secured state. In manufacturing the pulse is ignored.
- R5: Advance in the shipped state moves the state to secured only when `appActive` is high and `dbgAuth` is low.
- R6: With `dbgAuth` high and the state not retired, `dbgLevel` selects the level: 0 diagnostics, 1 nonsecure, 2 application-root, 3 platform-root. At the next edge every enable at or below the requested level goes to 1. The enables are ordered `nsDbgEn` < `appDbgEn` < `rotDbgEn`, and level 0 opens none of them.
- R7: Every debug enable is 0 at the first edge after `dbgAuth` goes low.
- R8: Granting the platform-root level in any state other than manufacturing moves the state to manufacturing at the same edge and clears `appActive`. `attestable` is high only in the shipped or secured state, and it is never high while `rotDbgEn` is high.
- R9: `nsDbgSeen` rises with any nonsecure or application-root grant made outside manufacturing. It stays high until the state returns to manufacturing.
- R10: `cmdCode` 2'b10 (retire) moves any state to retired at the next edge and closes all enables, even with `dbgAuth` high. In the retired state no enable opens, `eraseReq` is high and `secretsValid` is low.
- R11: `cmdCode` 2'b11 (reclaim) moves retired to manufacturing. In every other state it is ignored, and advance is ignored in the retired state.
- R12: `secureBootReq` is high in every state except manufacturing. `secretsValid` is high only in shipped and secured, and `eraseReq` only in retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; loads the state from `loadState` |
| loadState | input | 4 | State presented by the persistent store |
| cmdCode | input | 2 | 00 none, 01 advance, 10 retire, 11 reclaim |
| rotProvisioned | input | 1 | Root-of-trust parameters are provisioned |
| dbgPortLocked | input | 1 | Debug port is locked |
| secureBootOn | input | 1 | Secure boot is enabled |
| appProvReq | input | 1 | Request to make the application active |
| dbgLevel | input | 2 | Requested debug level |
| dbgAuth | input | 1 | Debugger authorised this cycle |
| lcState | output | 4 | Decoded one-hot lifecycle state |
| appActive | output | 1 | Application provisioned or device onboarded |
| nsDbgEn | output | 1 | Nonsecure debug enable |
| appDbgEn | output | 1 | Application-root debug enable |
| rotDbgEn | output | 1 | Platform-root debug enable |
| nsDbgSeen | output | 1 | Intrusive debug was used since leaving manufacturing |
| attestable | output | 1 | Device may attest |
| secretsValid | output | 1 | Root-of-trust secrets are valid |
| secureBootReq | output | 1 | Secure boot is mandatory |
| eraseReq | output | 1 | Request to erase root-of-trust parameters |

## Verification
The bench loads illegal state words at reset. A design that trusted the raw register would report a non-one-hot state and never ask for an erase.

It tries an advance out of manufacturing with one condition missing, and again with the debugger still authorised. A loose guard would ship a device whose port is open.

It also opens platform-root debug in the secured state. A design that got this wrong would keep reporting `attestable`, or would stay in secured, which lets a compromised part return to operation.

Finally, it retires the device while authorisation is still held. It also sends reclaim and advance commands in states where both must do nothing.

// File: rtl/lcg_pkg.sv
package lcg_pkg;
  localparam int ST_W   = 4;
  localparam int LVL_W  = 2;
  localparam int CMD_W  = 2;
  localparam int NUM_EN = 3;

  typedef enum logic [ST_W-1:0] {
    LC_MANUF   = 4'b0001,
    LC_SHIPPED = 4'b0010,
    LC_SECURED = 4'b0100,
    LC_RETIRED = 4'b1000
  } lcState_e;

  localparam logic [CMD_W-1:0] CMD_NONE    = 2'b00;
  localparam logic [CMD_W-1:0] CMD_ADVANCE = 2'b01;
  localparam logic [CMD_W-1:0] CMD_RETIRE  = 2'b10;
  localparam logic [CMD_W-1:0] CMD_RECLAIM = 2'b11;

  typedef struct packed {
    logic              toManuf;
    logic              toShipped;
    logic              toSecured;
    logic              toRetired;
    logic              appAccept;
    logic [NUM_EN-1:0] grant;
  } lcStrobes_t;
endpackage

// File: rtl/lcg_ctrl.sv
module lcg_ctrl
  import lcg_pkg::*;
(
  input  lcState_e          curState,
  input  logic              appActive,
  input  logic [CMD_W-1:0]  cmdCode,
  input  logic              rotProvisioned,
  input  logic              dbgPortLocked,
  input  logic              secureBootOn,
  input  logic              appProvReq,
  input  logic [LVL_W-1:0]  dbgLevel,
  input  logic              dbgAuth,
  output lcStrobes_t        strobes
);
  logic [NUM_EN-1:0] levelMask;
  logic retireCmd;
  logic shipReady;

  // Level n opens every enable whose index is below n.
  for (genvar i = 0; i < NUM_EN; i++) begin : g_mask
    assign levelMask[i] = (dbgLevel > LVL_W'(i));
  end

  assign retireCmd = (cmdCode == CMD_RETIRE);
  assign shipReady = rotProvisioned && dbgPortLocked && secureBootOn;

  always_comb begin
    strobes = '0;
    strobes.grant = (dbgAuth && !retireCmd && curState != LC_RETIRED) ? levelMask : '0;
    strobes.appAccept = appProvReq &&
                        (curState == LC_SHIPPED || curState == LC_SECURED);
    if (retireCmd) begin
      strobes.toRetired = 1'b1;
    end else if (strobes.grant[NUM_EN-1] && curState != LC_MANUF) begin
      // Platform-root debug outside manufacturing forces re-provisioning.
      strobes.toManuf = 1'b1;
    end else begin
      case (cmdCode)
        CMD_ADVANCE: begin
          if (!dbgAuth) begin
            if (curState == LC_MANUF && shipReady) strobes.toShipped = 1'b1;
            else if (curState == LC_SHIPPED && appActive) strobes.toSecured = 1'b1;
          end
        end
        CMD_RECLAIM: begin
          if (curState == LC_RETIRED) strobes.toManuf = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lcg_dpath.sv
module lcg_dpath
  import lcg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ST_W-1:0]   loadState,
  input  lcStrobes_t        strobes,
  output lcState_e          curState,
  output logic              appActive,
  output logic [NUM_EN-1:0] enables,
  output logic              nsDbgSeen,
  output logic              attestable,
  output logic              secretsValid,
  output logic              secureBootReq,
  output logic              eraseReq
);
  logic [ST_W-1:0]   stateQ;
  logic [NUM_EN-1:0] enQ;
  logic              appQ;
  logic              seenQ;
  lcState_e          nextState;
  logic              nextLive;

  // A word that is not one-hot fails safe to the retired state.
  assign curState = $onehot(stateQ) ? lcState_e'(stateQ) : LC_RETIRED;

  always_comb begin
    if (strobes.toRetired)      nextState = LC_RETIRED;
    else if (strobes.toManuf)   nextState = LC_MANUF;
    else if (strobes.toShipped) nextState = LC_SHIPPED;
    else if (strobes.toSecured) nextState = LC_SECURED;
    else                        nextState = curState;
  end

  assign nextLive = (nextState == LC_SHIPPED) || (nextState == LC_SECURED);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= loadState;
      enQ    <= '0;
      appQ   <= 1'b0;
      seenQ  <= 1'b0;
    end else begin
      stateQ <= nextState;
      enQ    <= strobes.grant;
      appQ   <= nextLive && (appQ || strobes.appAccept);
      seenQ  <= (nextState != LC_MANUF) && (seenQ || strobes.grant[0]);
    end
  end

  assign enables       = enQ;
  assign nsDbgSeen     = seenQ;
  assign appActive     = appQ || (curState == LC_SECURED);
  assign attestable    = (curState == LC_SHIPPED) || (curState == LC_SECURED);
  assign secretsValid  = attestable;
  assign secureBootReq = (curState != LC_MANUF);
  assign eraseReq      = (curState == LC_RETIRED);
endmodule

// File: rtl/lifecycle_guard.sv
module lifecycle_guard
  import lcg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  loadState,
  input  logic [1:0]  cmdCode,
  input  logic        rotProvisioned,
  input  logic        dbgPortLocked,
  input  logic        secureBootOn,
  input  logic        appProvReq,
  input  logic [1:0]  dbgLevel,
  input  logic        dbgAuth,
  output logic [3:0]  lcState,
  output logic        appActive,
  output logic        nsDbgEn,
  output logic        appDbgEn,
  output logic        rotDbgEn,
  output logic        nsDbgSeen,
  output logic        attestable,
  output logic        secretsValid,
  output logic        secureBootReq,
  output logic        eraseReq
);
  lcStrobes_t        strobes;
  lcState_e          curState;
  logic [NUM_EN-1:0] enables;

  lcg_ctrl u_ctrl (
    .curState      (curState),
    .appActive     (appActive),
    .cmdCode       (cmdCode),
    .rotProvisioned(rotProvisioned),
    .dbgPortLocked (dbgPortLocked),
    .secureBootOn  (secureBootOn),
    .appProvReq    (appProvReq),
    .dbgLevel      (dbgLevel),
    .dbgAuth       (dbgAuth),
    .strobes       (strobes)
  );

  lcg_dpath u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .loadState    (loadState),
    .strobes      (strobes),
    .curState     (curState),
    .appActive    (appActive),
    .enables      (enables),
    .nsDbgSeen    (nsDbgSeen),
    .attestable   (attestable),
    .secretsValid (secretsValid),
    .secureBootReq(secureBootReq),
    .eraseReq     (eraseReq)
  );

  assign lcState  = curState;
  assign nsDbgEn  = enables[0];
  assign appDbgEn = enables[1];
  assign rotDbgEn = enables[2];
endmodule

// File: rtl/lcg_checker.sv
module lcg_checker
  import lcg_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  loadState,
  input logic [1:0]  cmdCode,
  input logic        rotProvisioned,
  input logic        dbgPortLocked,
  input logic        secureBootOn,
  input logic        appProvReq,
  input logic [1:0]  dbgLevel,
  input logic        dbgAuth,
  input logic [3:0]  lcState,
  input logic        appActive,
  input logic        nsDbgEn,
  input logic        appDbgEn,
  input logic        rotDbgEn,
  input logic        nsDbgSeen,
  input logic        attestable,
  input logic        secretsValid,
  input logic        secureBootReq,
  input logic        eraseReq
);
  assert_state_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot(lcState));

  assert_enables_need_auth_R7: assert property (@(posedge clk) disable iff (!rstN)
    (nsDbgEn || appDbgEn || rotDbgEn) |-> $past(dbgAuth));

  assert_level_order_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rotDbgEn |-> appDbgEn) and (appDbgEn |-> nsDbgEn));

  assert_rot_not_attestable_R8: assert property (@(posedge clk) disable iff (!rstN)
    rotDbgEn |-> !attestable);

  assert_retired_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (lcState == LC_RETIRED) |-> (!nsDbgEn && eraseReq && !secretsValid));

  assert_reclaim_target_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lcState) == LC_RETIRED && lcState != LC_RETIRED) |-> (lcState == LC_MANUF));

  assert_advance_guard_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lcState) == LC_MANUF && lcState == LC_SHIPPED) |->
      $past(rotProvisioned && dbgPortLocked && secureBootOn && !dbgAuth));

  assert_onboard_needs_app_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(lcState) == LC_SHIPPED && lcState == LC_SECURED) |-> $past(appActive));
endmodule

bind lifecycle_guard lcg_checker u_chk (.*);

// File: tb/tb_lifecycle_guard.sv
`timescale 1ns/1ps
module tb_lifecycle_guard;
  localparam logic [3:0] ST_M = 4'b0001, ST_S = 4'b0010, ST_C = 4'b0100, ST_R = 4'b1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] loadState = ST_M;
  logic [1:0] cmdCode = 2'b00;
  logic rotProvisioned = 1'b0, dbgPortLocked = 1'b0, secureBootOn = 1'b0;
  logic appProvReq = 1'b0;
  logic [1:0] dbgLevel = 2'd0;
  logic dbgAuth = 1'b0;
  logic [3:0] lcState;
  logic appActive, nsDbgEn, appDbgEn, rotDbgEn, nsDbgSeen;
  logic attestable, secretsValid, secureBootReq, eraseReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lifecycle_guard dut (.*);

  typedef struct packed {
    logic [1:0] cmd;
    logic [1:0] lvl;
    logic       auth;
    logic [2:0] cond;   // {rotProvisioned, dbgPortLocked, secureBootOn}
    logic       appReq;
    logic [3:0] st;
    logic [2:0] en;     // {rot, app, ns}
    logic       att;
    logic       app;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 2'd3, 1'b1, 3'b000, 1'b0, 4'b0001, 3'b111, 1'b0, 1'b0, 4'd6},  // R6 full debug in manufacturing
    '{2'b00, 2'd3, 1'b0, 3'b000, 1'b0, 4'b0001, 3'b000, 1'b0, 1'b0, 4'd7},  // R7 auth removed
    '{2'b00, 2'd0, 1'b0, 3'b000, 1'b1, 4'b0001, 3'b000, 1'b0, 1'b0, 4'd4},  // R4 app request too early
    '{2'b01, 2'd0, 1'b0, 3'b011, 1'b0, 4'b0001, 3'b000, 1'b0, 1'b0, 4'd3},  // R3 not provisioned
    '{2'b01, 2'd0, 1'b1, 3'b111, 1'b0, 4'b0001, 3'b000, 1'b0, 1'b0, 4'd3},  // R3 auth held, level 0
    '{2'b01, 2'd0, 1'b0, 3'b111, 1'b0, 4'b0010, 3'b000, 1'b1, 1'b0, 4'd3},  // R3 ship
    '{2'b01, 2'd0, 1'b0, 3'b111, 1'b0, 4'b0010, 3'b000, 1'b1, 1'b0, 4'd5},  // R5 no app yet
    '{2'b00, 2'd0, 1'b0, 3'b111, 1'b1, 4'b0010, 3'b000, 1'b1, 1'b1, 4'd4},  // R4 app accepted
    '{2'b01, 2'd0, 1'b0, 3'b111, 1'b0, 4'b0100, 3'b000, 1'b1, 1'b1, 4'd5},  // R5 onboard
    '{2'b00, 2'd1, 1'b1, 3'b111, 1'b0, 4'b0100, 3'b001, 1'b1, 1'b1, 4'd6},  // R6 nonsecure
    '{2'b00, 2'd2, 1'b1, 3'b111, 1'b0, 4'b0100, 3'b011, 1'b1, 1'b1, 4'd6},  // R6 app-root
    '{2'b00, 2'd2, 1'b0, 3'b111, 1'b0, 4'b0100, 3'b000, 1'b1, 1'b1, 4'd7},  // R7 close
    '{2'b00, 2'd3, 1'b1, 3'b111, 1'b0, 4'b0001, 3'b111, 1'b0, 1'b0, 4'd8},  // R8 platform-root drops state
    '{2'b00, 2'd0, 1'b0, 3'b111, 1'b0, 4'b0001, 3'b000, 1'b0, 1'b0, 4'd8},  // R8 stays non-attestable
    '{2'b11, 2'd0, 1'b0, 3'b111, 1'b0, 4'b0001, 3'b000, 1'b0, 1'b0, 4'd11}, // R11 reclaim ignored
    '{2'b10, 2'd0, 1'b0, 3'b111, 1'b0, 4'b1000, 3'b000, 1'b0, 1'b0, 4'd10}, // R10 retire
    '{2'b00, 2'd3, 1'b1, 3'b111, 1'b0, 4'b1000, 3'b000, 1'b0, 1'b0, 4'd10}, // R10 no debug retired
    '{2'b01, 2'd0, 1'b0, 3'b111, 1'b0, 4'b1000, 3'b000, 1'b0, 1'b0, 4'd11}, // R11 advance ignored
    '{2'b11, 2'd0, 1'b0, 3'b111, 1'b0, 4'b0001, 3'b000, 1'b0, 1'b0, 4'd11}  // R11 reclaim
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] cmd, input logic [1:0] lvl, input logic auth,
                       input logic [2:0] cond, input logic appReq);
    @(negedge clk);
    cmdCode = cmd; dbgLevel = lvl; dbgAuth = auth;
    {rotProvisioned, dbgPortLocked, secureBootOn} = cond;
    appProvReq = appReq;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic [3:0] ld);
    @(negedge clk);
    rstN = 1'b0; loadState = ld;
    cmdCode = 2'b00; dbgAuth = 1'b0; dbgLevel = 2'd0; appProvReq = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  // R12 flags follow directly from the expected state.
  task automatic check_flags(input string tag, input logic [3:0] st);
    check({tag, " R12 secureBootReq"}, secureBootReq, st != ST_M);
    check({tag, " R12 secretsValid"}, secretsValid, (st == ST_S) || (st == ST_C));
    check({tag, " R12 eraseReq"}, eraseReq, st == ST_R);
  endtask

  initial begin
    do_reset(ST_M);
    check("R1 reset state manuf", lcState, ST_M);
    check("R1 reset enables", {rotDbgEn, appDbgEn, nsDbgEn}, 3'b000);
    check("R1 reset appActive", appActive, 1'b0);
    check("R1 reset nsDbgSeen", nsDbgSeen, 1'b0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      drive(VECS[i].cmd, VECS[i].lvl, VECS[i].auth, VECS[i].cond, VECS[i].appReq);
      check({tag, " state"}, lcState, VECS[i].st);
      check({tag, " enables"}, {rotDbgEn, appDbgEn, nsDbgEn}, VECS[i].en);
      check({tag, " attestable"}, attestable, VECS[i].att);
      check({tag, " appActive"}, appActive, VECS[i].app);
      check_flags(tag, VECS[i].st);
    end

    // R1: legal loads of shipped and secured
    do_reset(ST_S);
    check("R1 load shipped", lcState, ST_S);
    check("R1 load shipped appActive", appActive, 1'b0);
    do_reset(ST_C);
    check("R1 load secured", lcState, ST_C);
    check("R1 load secured appActive", appActive, 1'b1);

    // R2: illegal encodings fail safe
    do_reset(4'b0110);
    check("R2 load 0110 state", lcState, ST_R);
    check("R2 load 0110 eraseReq", eraseReq, 1'b1);
    check("R2 load 0110 secretsValid", secretsValid, 1'b0);
    drive(2'b00, 2'd0, 1'b0, 3'b000, 1'b0);
    check("R2 held after a clock", lcState, ST_R);
    do_reset(4'b0000);
    check("R2 load 0000 state", lcState, ST_R);

    // R9: debug use recorded until manufacturing
    do_reset(ST_C);
    drive(2'b00, 2'd1, 1'b1, 3'b000, 1'b0);
    check("R9 seen on nonsecure grant", nsDbgSeen, 1'b1);
    drive(2'b00, 2'd1, 1'b0, 3'b000, 1'b0);
    check("R9 seen sticky", nsDbgSeen, 1'b1);
    check("R7 closed", nsDbgEn, 1'b0);
    drive(2'b11, 2'd0, 1'b0, 3'b000, 1'b0);
    check("R11 reclaim ignored in secured", lcState, ST_C);
    drive(2'b10, 2'd0, 1'b0, 3'b000, 1'b0);
    check("R9 seen kept in retired", nsDbgSeen, 1'b1);
    drive(2'b11, 2'd0, 1'b0, 3'b000, 1'b0);
    check("R11 reclaim to manuf", lcState, ST_M);
    check("R9 seen cleared in manuf", nsDbgSeen, 1'b0);

    // R10: retire while authorisation is still held
    do_reset(ST_S);
    drive(2'b00, 2'd2, 1'b1, 3'b000, 1'b0);
    check("R6 app-root in shipped", {rotDbgEn, appDbgEn, nsDbgEn}, 3'b011);
    drive(2'b10, 2'd2, 1'b1, 3'b000, 1'b0);
    check("R10 retire state", lcState, ST_R);
    check("R10 retire closes enables", {rotDbgEn, appDbgEn, nsDbgEn}, 3'b000);
    check("R10 retire eraseReq", eraseReq, 1'b1);
    check("R10 retire secretsValid", secretsValid, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule